// File: doc/BRIEF.md
# Privilege-Mode Banked Register File

This block holds the architectural integer registers of a 32-bit processor core that runs in several privilege modes. Sixteen general registers are visible at any time and are served by two combinational read ports and one synchronous write port. A saved-status register is also visible, with its own read and write path. Some of the visible registers are backed by hidden copies, one per mode group. A mode-change request swaps the hidden copies in and out within the same clock edge that records the new mode.

The exception modes (fast interrupt, interrupt, supervisor, abort, undefined) each keep a private stack pointer (r13), link register (r14) and saved status. User mode, system mode and any unrecognised encoding share one unbanked set. Registers r8 to r12 have two copies. One belongs to the fast-interrupt mode and the other is shared by every other mode. They are exchanged only when the fast-interrupt mode is entered or left. The surrounding core drives the new mode and reads back the current one. Decode, flag logic and exception sequencing stay outside this block.

Top module: `mbrf_top`

## Requirements
- R1: A synchronous active-high reset clears all sixteen visible registers, every hidden r13/r14/status copy, both r8–r12 copies and the visible status, and sets the current mode to system (5'h1F).
- R2: Each read port returns the visible register addressed by its 4-bit index combinationally. A write with `wr_en` high updates the addressed register at the next rising edge.
- R3: User (5'h10), system (5'h1F) and every encoding outside the list in R4 form one unbanked group. Changing between any two of them leaves r13, r14 and the visible status unchanged.
- R4: Fast interrupt (5'h11), interrupt (5'h12), supervisor (5'h13), abort (5'h17) and undefined (5'h1B) each own a private r13, r14 and status copy. Leaving a group stores the outgoing values into that group's slots. Entering a group makes its stored values visible one edge later.
- R5: r8–r12 are exchanged with their second copy only when the old or the new mode is fast interrupt. All other changes leave them untouched.
- R6: A request whose new mode maps to the current group leaves every register unchanged. This includes a request for the mode already in force.
- R7: A register or status write in the same cycle as a mode change lands in the outgoing mode's copy.
- R8: After a request, `mode_cur` shows the requested 5-bit encoding from the next edge on. Without a request it holds.
- R9: `spsr_wr_en` writes the visible status at the next edge, and `spsr_rd` always shows the visible status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr_a | input | 4 | Read port A register index |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 4 | Read port B register index |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| spsr_wr_en | input | 1 | Saved status write enable |
| spsr_wr_data | input | 32 | Saved status write data |
| spsr_rd | output | 32 | Visible saved status |
| mode_chg | input | 1 | Mode-change request |
| mode_new | input | 5 | Requested mode encoding |
| mode_cur | output | 5 | Current mode encoding |

## Verification
The bench builds the block with its default 32-bit word width. At that width, distinct per-register and per-bank data patterns expose any swap to the wrong slot. The stimulus walks the unbanked group, including an undefined encoding, then interrupt, supervisor and fast interrupt and back. This brings every exchange direction of r8–r12 and r13/r14 within reach, together with writes that coincide with a mode change. A second reset in mid-run shows that the hidden copies are cleared as well as the visible set.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int NUM_REGS  = 16;
    localparam int RIDX_W    = $clog2(NUM_REGS);
    localparam int SP_IDX    = 13;
    localparam int LR_IDX    = 14;
    localparam int HI_BASE   = 8;
    localparam int HI_CNT    = 5;
    localparam int NUM_BANKS = 6;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int MODE_W    = 5;

    typedef enum logic [MODE_W-1:0] {
        PM_USR = 5'h10,
        PM_FIQ = 5'h11,
        PM_IRQ = 5'h12,
        PM_SVC = 5'h13,
        PM_ABT = 5'h17,
        PM_UND = 5'h1B,
        PM_SYS = 5'h1F
    } pmode_e;

    typedef enum logic [BANK_W-1:0] {
        BK_PLAIN = 3'd0,
        BK_FIQ   = 3'd1,
        BK_IRQ   = 3'd2,
        BK_SVC   = 3'd3,
        BK_ABT   = 3'd4,
        BK_UND   = 3'd5
    } bank_e;

    typedef struct packed {
        logic  bank_sw;
        logic  hi_sw;
        bank_e old_bank;
        bank_e new_bank;
        logic  old_hi;
        logic  new_hi;
    } swap_ctl_t;

    function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
        bank_e b;
        case (m)
            PM_FIQ:  b = BK_FIQ;
            PM_IRQ:  b = BK_IRQ;
            PM_SVC:  b = BK_SVC;
            PM_ABT:  b = BK_ABT;
            PM_UND:  b = BK_UND;
            default: b = BK_PLAIN;
        endcase
        return b;
    endfunction

    function automatic logic uses_fiq_hi(input bank_e b);
        return (b == BK_FIQ);
    endfunction

endpackage

// File: rtl/rf_mode_ctl.sv
module rf_mode_ctl
    import rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_chg,
    input  logic [MODE_W-1:0] mode_new,
    output logic [MODE_W-1:0] mode_q,
    output swap_ctl_t         swap
);

    bank_e cur_bank;
    bank_e req_bank;
    logic  rst_seen_q;

    always_comb begin
        cur_bank      = bank_of(mode_q);
        req_bank      = bank_of(mode_new);
        swap.old_bank = cur_bank;
        swap.new_bank = req_bank;
        swap.old_hi   = uses_fiq_hi(cur_bank);
        swap.new_hi   = uses_fiq_hi(req_bank);
        swap.bank_sw  = mode_chg && (req_bank != cur_bank);
        swap.hi_sw    = swap.bank_sw && (swap.old_hi != swap.new_hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_SYS;
        end else if (mode_chg) begin
            mode_q <= mode_new;
        end
    end

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (!rst && rst_seen_q) begin
            AST_RESET_MODE: assert (mode_q == PM_SYS); // R1
        end
    end

    AST_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> (mode_q == $past(mode_new))); // R8

    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !mode_chg |=> $stable(mode_q)); // R8

endmodule

// File: rtl/rf_bank_store.sv
module rf_bank_store
    import rf_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  swap_ctl_t                    swap,
    input  logic [XLEN-1:0]              save_sp,
    input  logic [XLEN-1:0]              save_lr,
    input  logic [XLEN-1:0]              save_spsr,
    input  logic [HI_CNT-1:0][XLEN-1:0]  save_hi,
    output logic [XLEN-1:0]              load_sp,
    output logic [XLEN-1:0]              load_lr,
    output logic [XLEN-1:0]              load_spsr,
    output logic [HI_CNT-1:0][XLEN-1:0]  load_hi
);

    localparam int HI_SETS = 2;

    logic [NUM_BANKS-1:0][XLEN-1:0]           sp_m;
    logic [NUM_BANKS-1:0][XLEN-1:0]           lr_m;
    logic [NUM_BANKS-1:0][XLEN-1:0]           spsr_m;
    logic [HI_SETS-1:0][HI_CNT-1:0][XLEN-1:0] hi_m;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                sp_m[b]   <= '0;
                lr_m[b]   <= '0;
                spsr_m[b] <= '0;
            end else if (swap.bank_sw && (swap.old_bank == bank_e'(b))) begin
                sp_m[b]   <= save_sp;
                lr_m[b]   <= save_lr;
                spsr_m[b] <= save_spsr;
            end
        end
    end

    for (genvar s = 0; s < HI_SETS; s++) begin : g_hi
        always_ff @(posedge clk) begin
            if (rst) begin
                hi_m[s] <= '0;
            end else if (swap.hi_sw && (swap.old_hi == s[0])) begin
                hi_m[s] <= save_hi;
            end
        end
    end

    always_comb begin
        load_sp   = sp_m[swap.new_bank];
        load_lr   = lr_m[swap.new_bank];
        load_spsr = spsr_m[swap.new_bank];
        load_hi   = hi_m[swap.new_hi];
    end

    AST_BANK_SAVED: assert property (@(posedge clk) disable iff (rst)
        swap.bank_sw |=> (sp_m[$past(swap.old_bank)] == $past(save_sp))); // R4

    AST_HI_SAVED: assert property (@(posedge clk) disable iff (rst)
        swap.hi_sw |=> (hi_m[$past(swap.old_hi)] == $past(save_hi))); // R5

endmodule

// File: rtl/rf_visible.sv
module rf_visible
    import rf_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [RIDX_W-1:0]             wr_addr,
    input  logic [XLEN-1:0]               wr_data,
    input  logic                          spsr_wr_en,
    input  logic [XLEN-1:0]               spsr_wr_data,
    input  swap_ctl_t                     swap,
    input  logic [XLEN-1:0]               load_sp,
    input  logic [XLEN-1:0]               load_lr,
    input  logic [XLEN-1:0]               load_spsr,
    input  logic [HI_CNT-1:0][XLEN-1:0]   load_hi,
    output logic [NUM_REGS-1:0][XLEN-1:0] regs_q,
    output logic [XLEN-1:0]               spsr_q,
    output logic [XLEN-1:0]               save_sp,
    output logic [XLEN-1:0]               save_lr,
    output logic [XLEN-1:0]               save_spsr,
    output logic [HI_CNT-1:0][XLEN-1:0]   save_hi
);

    logic [NUM_REGS-1:0][XLEN-1:0] regs_post;
    logic [NUM_REGS-1:0][XLEN-1:0] regs_nx;
    logic [XLEN-1:0]               spsr_post;
    logic [XLEN-1:0]               spsr_nx;
    logic                          rst_seen_q;

    always_comb begin
        regs_post = regs_q;
        if (wr_en) begin
            regs_post[wr_addr] = wr_data;
        end
        spsr_post = spsr_wr_en ? spsr_wr_data : spsr_q;
    end

    always_comb begin
        save_sp   = regs_post[SP_IDX];
        save_lr   = regs_post[LR_IDX];
        save_spsr = spsr_post;
        for (int i = 0; i < HI_CNT; i++) begin
            save_hi[i] = regs_post[HI_BASE + i];
        end
    end

    always_comb begin
        regs_nx = regs_post;
        spsr_nx = spsr_post;
        if (swap.bank_sw) begin
            regs_nx[SP_IDX] = load_sp;
            regs_nx[LR_IDX] = load_lr;
            spsr_nx         = load_spsr;
        end
        if (swap.hi_sw) begin
            for (int i = 0; i < HI_CNT; i++) begin
                regs_nx[HI_BASE + i] = load_hi[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
            spsr_q <= '0;
        end else begin
            regs_q <= regs_nx;
            spsr_q <= spsr_nx;
        end
    end

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (!rst && rst_seen_q) begin
            AST_RESET_CLEAR: assert (regs_q == '0 && spsr_q == '0); // R1
        end
    end

    AST_SAME_GROUP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!swap.bank_sw && !wr_en && !spsr_wr_en)
            |=> ($stable(regs_q) && $stable(spsr_q))); // R6

    AST_HI_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        (!swap.hi_sw && !wr_en)
            |=> $stable(regs_q[HI_BASE +: HI_CNT])); // R5

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !swap.bank_sw)
            |=> (regs_q[$past(wr_addr)] == $past(wr_data))); // R2

endmodule

// File: rtl/mbrf_top.sv
module mbrf_top
    import rf_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        rd_addr_a,
    output logic [XLEN-1:0]   rd_data_a,
    input  logic [3:0]        rd_addr_b,
    output logic [XLEN-1:0]   rd_data_b,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [XLEN-1:0]   wr_data,
    input  logic              spsr_wr_en,
    input  logic [XLEN-1:0]   spsr_wr_data,
    output logic [XLEN-1:0]   spsr_rd,
    input  logic              mode_chg,
    input  logic [4:0]        mode_new,
    output logic [4:0]        mode_cur
);

    swap_ctl_t                     swap;
    logic [NUM_REGS-1:0][XLEN-1:0] regs_q;
    logic [XLEN-1:0]               spsr_q;
    logic [XLEN-1:0]               save_sp, save_lr, save_spsr;
    logic [XLEN-1:0]               load_sp, load_lr, load_spsr;
    logic [HI_CNT-1:0][XLEN-1:0]   save_hi, load_hi;

    rf_mode_ctl u_mode (
        .clk      (clk),
        .rst      (rst),
        .mode_chg (mode_chg),
        .mode_new (mode_new),
        .mode_q   (mode_cur),
        .swap     (swap)
    );

    rf_bank_store #(.XLEN(XLEN)) u_store (
        .clk       (clk),
        .rst       (rst),
        .swap      (swap),
        .save_sp   (save_sp),
        .save_lr   (save_lr),
        .save_spsr (save_spsr),
        .save_hi   (save_hi),
        .load_sp   (load_sp),
        .load_lr   (load_lr),
        .load_spsr (load_spsr),
        .load_hi   (load_hi)
    );

    rf_visible #(.XLEN(XLEN)) u_vis (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .spsr_wr_en   (spsr_wr_en),
        .spsr_wr_data (spsr_wr_data),
        .swap         (swap),
        .load_sp      (load_sp),
        .load_lr      (load_lr),
        .load_spsr    (load_spsr),
        .load_hi      (load_hi),
        .regs_q       (regs_q),
        .spsr_q       (spsr_q),
        .save_sp      (save_sp),
        .save_lr      (save_lr),
        .save_spsr    (save_spsr),
        .save_hi      (save_hi)
    );

    assign rd_data_a = regs_q[rd_addr_a];
    assign rd_data_b = regs_q[rd_addr_b];
    assign spsr_rd   = spsr_q;

endmodule

// File: tb/tb_mbrf_top.sv
`timescale 1ns/1ps
module tb_mbrf_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [31:0] rd_data_a, rd_data_b, wr_data = '0, spsr_wr_data = '0, spsr_rd;
    logic        wr_en = 1'b0, spsr_wr_en = 1'b0, mode_chg = 1'b0;
    logic [4:0]  mode_new = '0, mode_cur;

    always #2.5 clk = ~clk;

    mbrf_top dut (.*);

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc   = 0;

    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                0: act = rd_data_a;
                1: act = rd_data_b;
                2: act = spsr_rd;
                default: act = {27'd0, mode_cur};
            endcase
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FIAL-free check %s kind %0d: actual %h expected %h",
                         it.req, it.kind, act, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic idle_ctl();
        wr_en = 1'b0; spsr_wr_en = 1'b0; mode_chg = 1'b0;
    endtask

    task automatic op(input logic we, input logic [3:0] wa, input logic [31:0] wd,
                      input logic se, input logic [31:0] sd,
                      input logic mc, input logic [4:0] mn);
        @(posedge clk); #1;
        wr_en = we; wr_addr = wa; wr_data = wd;
        spsr_wr_en = se; spsr_wr_data = sd;
        mode_chg = mc; mode_new = mn;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        op(1'b1, a, d, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic chmode(input logic [4:0] m);
        op(1'b0, '0, '0, 1'b0, '0, 1'b1, m);
    endtask

    task automatic chk(input int kind, input logic [3:0] a,
                       input logic [31:0] e, input string req);
        item_t it;
        @(posedge clk); #1;
        idle_ctl();
        if (kind == 1) rd_addr_b = a; else rd_addr_a = a;
        it.kind = kind; it.exp = e; it.req = req;
        q.push_back(it);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        idle_ctl();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1: reset state
        chk(0, 4'd0,  32'h0, "R1");
        chk(1, 4'd13, 32'h0, "R1");
        chk(2, 4'd0,  32'h0, "R1");
        chk(3, 4'd0,  32'h1F, "R1");

        // R2: fill the visible set in system mode
        for (int i = 0; i < 16; i++) wr(4'(i), 32'h1000_0000 + i);
        chk(0, 4'd5,  32'h1000_0005, "R2");
        chk(1, 4'd14, 32'h1000_000E, "R2");
        chk(0, 4'd15, 32'h1000_000F, "R2");

        // R3: user, then undefined encoding, stay unbanked
        chmode(5'h10);
        chk(0, 4'd13, 32'h1000_000D, "R3");
        chk(3, 4'd0,  32'h10, "R8");
        chmode(5'h05);
        chk(1, 4'd14, 32'h1000_000E, "R3");

        // R4: interrupt mode has fresh private copies
        chmode(5'h12);
        chk(0, 4'd13, 32'h0, "R4");
        chk(1, 4'd14, 32'h0, "R4");
        chk(0, 4'd8,  32'h1000_0008, "R5");
        chk(2, 4'd0,  32'h0, "R4");
        wr(4'd13, 32'hA000_0013);
        op(1'b0, '0, '0, 1'b1, 32'hA000_005A, 1'b0, '0);
        chk(2, 4'd0, 32'hA000_005A, "R9");
        chmode(5'h13);
        chk(0, 4'd13, 32'h0, "R4");
        wr(4'd13, 32'hB000_0013);
        chmode(5'h12);
        chk(0, 4'd13, 32'hA000_0013, "R4");
        chk(2, 4'd0,  32'hA000_005A, "R4");

        // R6: same-mode request with a write in the same cycle
        op(1'b1, 4'd14, 32'hA000_000E, 1'b0, '0, 1'b1, 5'h12);
        chk(0, 4'd14, 32'hA000_000E, "R6");
        chk(1, 4'd13, 32'hA000_0013, "R6");
        chk(3, 4'd0,  32'h12, "R6");

        // R7 + R5: enter fast interrupt while writing r9 (goes to shared copy)
        op(1'b1, 4'd9, 32'hC000_0009, 1'b0, '0, 1'b1, 5'h11);
        chk(0, 4'd8,  32'h0, "R5");
        chk(1, 4'd9,  32'h0, "R5");
        chk(0, 4'd13, 32'h0, "R4");
        wr(4'd8,  32'hF000_0008);
        wr(4'd13, 32'hF000_000D);
        chmode(5'h13);
        chk(0, 4'd8,  32'h1000_0008, "R5");
        chk(1, 4'd9,  32'hC000_0009, "R7");
        chk(0, 4'd13, 32'hB000_0013, "R4");
        chmode(5'h11);
        chk(0, 4'd8,  32'hF000_0008, "R5");
        chk(1, 4'd13, 32'hF000_000D, "R4");

        // R7: write r13 while leaving fast interrupt for system
        op(1'b1, 4'd13, 32'hDDDD_0013, 1'b0, '0, 1'b1, 5'h1F);
        chk(0, 4'd13, 32'h1000_000D, "R3");
        chk(1, 4'd8,  32'h1000_0008, "R5");
        chmode(5'h11);
        chk(0, 4'd13, 32'hDDDD_0013, "R7");

        // R1: reset in mid-run clears hidden copies too
        do_reset();
        chk(3, 4'd0,  32'h1F, "R1");
        chk(0, 4'd13, 32'h0, "R1");
        chmode(5'h12);
        chk(0, 4'd13, 32'h0, "R1");
        chmode(5'h11);
        chk(1, 4'd8,  32'h0, "R1");

        repeat (3) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule